// File: doc/BRIEF.md
# Key-protected watchdog timer

A watchdog peripheral seen by software as four 32-bit words. The first word sets the operating mode, the second the clock divider and coarse timeout, the third is a restart (kick) port and the fourth reports whether the timeout has expired. Changes to mode and control are refused unless the written word carries a key specific to that register. A stray write therefore cannot disarm or retune the watchdog.

Once enabled, a 24-bit down-counter is loaded from the coarse timeout field, with its low bits forced to ones, and decrements on a divided clock. When it reaches zero it latches a sticky expiry flag. It can also drive a reset pulse and an interrupt pulse, each with a width chosen by a power-of-two code. The counter then holds until software reloads it with the restart key or with a keyed mode write.

The register port is a plain single-cycle write strobe with a combinational read path addressed by the same address pins. It always accepts and applies no back-pressure, since the block carries no data stream.

Top module: `key_watchdog`

## Requirements
- R1: After reset the mode word reads 0x000001C2, the control word reads 0x00003FFC, the restart and status words read 0, both pulse outputs are low, and the counter is stopped, so no pulse appears until software enables it.
- R2: Address bits [3:2] select the word: 0x0 mode, 0x4 control, 0x8 restart, 0xC status. A write is applied only when all four byte enables are set and address bits [1:0] are zero. Any other write changes nothing.
- R3: A mode write whose bits [23:12] equal 0xABC stores the word, with bits 3, [11:9] and [31:24] reading back as zero. Field positions: enable bit 0, reset-enable bit 1, interrupt-enable bit 2, reset width code [6:4], interrupt width code [8:7]. A mode write with any other key leaves the mode word unchanged.
- R4: A control write whose bits [25:14] equal 0x248 stores bits [25:0], with divider select in [1:0] and coarse timeout in [13:2]. Bits [31:26] read as zero. Any other key leaves the control word unchanged. A control write does not reload the counter.
- R5: A write to the restart word whose low 16 bits equal 0x1999 reloads the counter, whatever the upper bits hold. Other values have no effect. The restart word always reads 0, and writes to the status word are ignored.
- R6: The reload count is the coarse timeout followed by FILL_W one bits (12 by default). The counter steps once every 8 << (3 × select) clocks. The divider restarts on every reload, so expiry falls exactly ratio × count clock edges after the reloading edge.
- R7: At the expiring edge, status bit 0 is set. If reset-enable is set, the reset output goes high for exactly 2 << code clocks. If interrupt-enable is set, the interrupt output goes high for exactly 4 << code clocks. Both start at that same edge.
- R8: After expiry the counter holds, no further pulse appears, and the status bit stays set until a reload.
- R9: A keyed mode write with enable set, or a restart-key write while enabled, reloads the counter and clears status. A keyed mode write with enable clear stops counting and leaves status unchanged. A restart-key write while disabled does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_be | input | 4 | Byte enables; all ones required for a write |
| bus_addr | input | ADDR_W | Byte address for write and read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| irq_o | output | 1 | Interrupt pulse on expiry |
| rst_o | output | 1 | Reset pulse on expiry |

## Verification
The checker assumes that every bus input is a known value while the write strobe is high, and that each strobe stands for one access per clock. It also assumes the key bits it inspects come straight from the write data of that cycle. The bench drives all bus pins only at falling edges and holds the strobe for exactly one cycle. Its random writes take fully defined words from $urandom, so keys, partial enables and misaligned addresses vary without ever going unknown.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int WORD_W = 32;
  localparam int KEY_W  = 12;

  localparam logic [1:0] IDX_MODE = 2'd0;
  localparam logic [1:0] IDX_CTRL = 2'd1;
  localparam logic [1:0] IDX_KICK = 2'd2;
  localparam logic [1:0] IDX_STAT = 2'd3;

  localparam logic [KEY_W-1:0] MODE_KEY = 12'hABC;
  localparam logic [KEY_W-1:0] CTRL_KEY = 12'h248;
  localparam logic [15:0]      KICK_KEY = 16'h1999;

  localparam logic [WORD_W-1:0] MODE_RST   = 32'h0000_01C2;
  localparam logic [WORD_W-1:0] CTRL_RST   = 32'h0000_3FFC;
  localparam logic [WORD_W-1:0] MODE_WMASK = 32'h00FF_F1F7;

  localparam int MKEY_LSB = 12;
  localparam int EN_BIT   = 0;
  localparam int RSTE_BIT = 1;
  localparam int IRQE_BIT = 2;
  localparam int RCODE_LSB = 4;
  localparam int RCODE_W   = 3;
  localparam int ICODE_LSB = 7;
  localparam int ICODE_W   = 2;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int COARSE_W = 12,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  input  logic              status_i,
  output logic [WORD_W-1:0] bus_rdata,
  output logic [WORD_W-1:0] mode_q,
  output logic [WORD_W-1:0] ctrl_q,
  output logic              load_o,
  output logic              stop_o
);
  localparam int CKEY_LSB = SEL_W + COARSE_W;
  localparam int CTRL_TOP = CKEY_LSB + KEY_W;
  localparam logic [WORD_W-1:0] CTRL_MASK = WORD_W'((64'd1 << CTRL_TOP) - 64'd1);

  logic       aligned;
  logic [1:0] idx;
  logic       wr_ok;
  logic       mode_ok, ctrl_ok, kick_ok;

  assign aligned = (bus_addr[1:0] == 2'b00) && ((bus_addr >> 4) == '0);
  assign idx     = bus_addr[3:2];
  assign wr_ok   = bus_wr && (bus_be == 4'hF) && aligned;

  assign mode_ok = wr_ok && (idx == IDX_MODE) &&
                   (bus_wdata[MKEY_LSB +: KEY_W] == MODE_KEY);
  assign ctrl_ok = wr_ok && (idx == IDX_CTRL) &&
                   (bus_wdata[CKEY_LSB +: KEY_W] == CTRL_KEY);
  assign kick_ok = wr_ok && (idx == IDX_KICK) && (bus_wdata[15:0] == KICK_KEY);

  // reload follows the enable bit in force after the write
  assign load_o = (mode_ok && bus_wdata[EN_BIT]) || (kick_ok && mode_q[EN_BIT]);
  assign stop_o = mode_ok && !bus_wdata[EN_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
      ctrl_q <= CTRL_RST;
    end else begin
      if (mode_ok) mode_q <= bus_wdata & MODE_WMASK;
      if (ctrl_ok) ctrl_q <= bus_wdata & CTRL_MASK;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (aligned) begin
      case (idx)
        IDX_MODE: bus_rdata = mode_q;
        IDX_CTRL: bus_rdata = ctrl_q;
        IDX_STAT: bus_rdata = {{(WORD_W-1){1'b0}}, status_i};
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3,
  parameter int STEP_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  localparam int ACC_W = BASE_LOG2 + STEP_LOG2 * ((1 << SEL_W) - 1);
  localparam int SPN_W = ACC_W + 1;

  logic [ACC_W-1:0] acc_q;
  logic [7:0]       shamt;
  logic [SPN_W-1:0] span, limit;

  assign shamt  = 8'(BASE_LOG2 + STEP_LOG2 * int'(sel_i));
  assign span   = SPN_W'(1) << shamt;
  assign limit  = span - SPN_W'(1);
  // >= keeps a select change mid-period from wrapping the accumulator
  assign tick_o = run_i && ({1'b0, acc_q} >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          acc_q <= '0;
    else if (!run_i || clear_i || tick_o) acc_q <= '0;
    else                                 acc_q <= acc_q + ACC_W'(1);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int COARSE_W  = 12,
  parameter int FILL_W    = 12,
  parameter int SEL_W     = 2,
  parameter int BASE_LOG2 = 3,
  parameter int STEP_LOG2 = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic                stop_i,
  input  logic [COARSE_W-1:0] coarse_i,
  input  logic [SEL_W-1:0]    sel_i,
  output logic                running_o,
  output logic                expire_o,
  output logic                status_o
);
  localparam int CNT_W = COARSE_W + FILL_W;

  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  wdt_prescaler #(
    .SEL_W(SEL_W), .BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)
  ) u_pre (
    .clk(clk), .rst_n(rst_n), .run_i(running_o),
    .clear_i(load_i || stop_i), .sel_i(sel_i), .tick_o(tick)
  );

  assign expire_o = running_o && tick && !load_i && !stop_i &&
                    (cnt_q == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      running_o <= 1'b0;
      status_o  <= 1'b0;
    end else if (load_i) begin
      cnt_q     <= {coarse_i, {FILL_W{1'b1}}};
      running_o <= 1'b1;
      status_o  <= 1'b0;
    end else if (stop_i) begin
      running_o <= 1'b0;
    end else if (running_o && tick) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        running_o <= 1'b0;
        status_o  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int CODE_W    = 2,
  parameter int BASE_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              pulse_o
);
  localparam int MAX_LOG2 = BASE_LOG2 + (1 << CODE_W) - 1;
  localparam int LEN_W    = MAX_LOG2 + 1;

  logic [LEN_W-1:0] left_q, len_m1;
  logic [7:0]       shamt;

  assign shamt  = 8'(BASE_LOG2 + int'(code_i));
  assign len_m1 = (LEN_W'(1) << shamt) - LEN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_o <= 1'b0;
      left_q  <= '0;
    end else if (fire_i) begin
      pulse_o <= 1'b1;
      left_q  <= len_m1;
    end else if (pulse_o) begin
      if (left_q == '0) pulse_o <= 1'b0;
      else              left_q  <= left_q - LEN_W'(1);
    end
  end
endmodule

// File: rtl/key_watchdog.sv
module key_watchdog
  import wdt_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int COARSE_W = 12,
  parameter int FILL_W   = 12,
  parameter int SEL_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [3:0]        bus_be,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              rst_o
);
  logic [WORD_W-1:0] mode_q, ctrl_q;
  logic load, stop, running, expire, status;

  wdt_regs #(.ADDR_W(ADDR_W), .COARSE_W(COARSE_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .status_i(status),
    .bus_rdata(bus_rdata), .mode_q(mode_q), .ctrl_q(ctrl_q),
    .load_o(load), .stop_o(stop)
  );

  wdt_counter #(
    .COARSE_W(COARSE_W), .FILL_W(FILL_W), .SEL_W(SEL_W),
    .BASE_LOG2(3), .STEP_LOG2(3)
  ) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_i(load), .stop_i(stop),
    .coarse_i(ctrl_q[SEL_W +: COARSE_W]), .sel_i(ctrl_q[SEL_W-1:0]),
    .running_o(running), .expire_o(expire), .status_o(status)
  );

  wdt_pulse #(.CODE_W(RCODE_W), .BASE_LOG2(1)) u_rst_pulse (
    .clk(clk), .rst_n(rst_n), .fire_i(expire && mode_q[RSTE_BIT]),
    .code_i(mode_q[RCODE_LSB +: RCODE_W]), .pulse_o(rst_o)
  );

  wdt_pulse #(.CODE_W(ICODE_W), .BASE_LOG2(2)) u_irq_pulse (
    .clk(clk), .rst_n(rst_n), .fire_i(expire && mode_q[IRQE_BIT]),
    .code_i(mode_q[ICODE_LSB +: ICODE_W]), .pulse_o(irq_o)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int IRQ_MAX = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_wr,
  input logic [3:0]  bus_be,
  input logic [11:0] mode_key_in,
  input logic [31:0] mode_q,
  input logic [31:0] ctrl_q,
  input logic        load,
  input logic        running,
  input logic        expire,
  input logic        status,
  input logic        irq_o
);
  logic [7:0] since_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_fire <= '0;
    else if (expire && mode_q[2])     since_fire <= '0;
    else if (since_fire != 8'hFF)     since_fire <= since_fire + 8'd1;
  end

  assert_partial_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_be != 4'hF) |=> ($stable(mode_q) && $stable(ctrl_q)));

  assert_bad_mode_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && mode_key_in != 12'hABC) |=> $stable(mode_q));

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(expire && mode_q[2]));

  assert_irq_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (since_fire < 8'(IRQ_MAX)));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !load) |=> status);

  assert_reload_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!status && running));

  assert_run_needs_enable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> mode_q[0]);
endmodule

bind key_watchdog wdt_checker u_wdt_checker (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_be(bus_be),
  .mode_key_in(bus_wdata[23:12]), .mode_q(mode_q), .ctrl_q(ctrl_q),
  .load(load), .running(running), .expire(expire), .status(status),
  .irq_o(irq_o)
);

// File: tb/tb_key_watchdog.sv
module tb_key_watchdog;
  localparam int FILL_W = 4;
  localparam logic [31:0] MKEY = 32'hABC << 12;
  localparam logic [31:0] CKEY = 32'h248 << 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [3:0] bus_be = 4'hF;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, wdt_rst;
  int n_chk = 0, n_bad = 0;
  logic [31:0] exp_mode = 32'h1C2, exp_ctrl = 32'h3FFC;

  always #10 clk = ~clk;

  key_watchdog #(.FILL_W(FILL_W)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq), .rst_o(wdt_rst)
  );

  function automatic logic [31:0] mode_word(int en, int rse, int ire, int rc, int ic);
    return MKEY | (32'(ic) << 7) | (32'(rc) << 4) | (32'(ire) << 2) | (32'(rse) << 1) | 32'(en);
  endfunction
  function automatic logic [31:0] ctrl_word(int crv, int sel);
    return CKEY | (32'(crv) << 2) | 32'(sel);
  endfunction
  function automatic logic [31:0] next_mode(logic [31:0] old, logic [3:0] a, logic [31:0] d, logic [3:0] be);
    if (a == 4'h0 && be == 4'hF && d[23:12] == 12'hABC) return d & 32'h00FF_F1F7;
    return old;
  endfunction
  function automatic logic [31:0] next_ctrl(logic [31:0] old, logic [3:0] a, logic [31:0] d, logic [3:0] be);
    if (a == 4'h4 && be == 4'hF && d[25:14] == 12'h248) return d & 32'h03FF_FFFF;
    return old;
  endfunction
  function automatic int period(int crv, int sel);
    return (8 << (3 * sel)) * ((crv << FILL_W) + (1 << FILL_W) - 1);
  endfunction

  task automatic check(string msg, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    exp_mode = next_mode(exp_mode, a, d, be);
    exp_ctrl = next_ctrl(exp_ctrl, a, d, be);
    @(negedge clk);
    bus_wr = 1'b0; bus_be = 4'hF;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic quiet(int n, string msg);
    int hit = 0;
    repeat (n) begin
      @(negedge clk);
      if (irq || wdt_rst) hit = 1;
    end
    check(msg, 32'(hit), 32'd0);
  endtask

  task automatic expect_expiry(string tag, int exp_cyc, int exp_iw, int exp_rw);
    int c = 0, iw = 0, rw = 0;
    logic [31:0] s;
    while (!(irq || wdt_rst) && c <= exp_cyc + 8) begin
      @(negedge clk);
      c++;
    end
    check({tag, " R6 expiry cycle"}, 32'(c), 32'(exp_cyc));
    while ((irq || wdt_rst) && (iw + rw) < 1000) begin
      if (irq) iw++;
      if (wdt_rst) rw++;
      @(negedge clk);
    end
    check({tag, " R7 irq width"}, 32'(iw), 32'(exp_iw));
    check({tag, " R7 rst width"}, 32'(rw), 32'(exp_rw));
    rd(4'hC, s);
    check({tag, " R7 status set"}, s, 32'd1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'h0, v); check("R1 mode reset", v, 32'h1C2);
    rd(4'h4, v); check("R1 control reset", v, 32'h3FFC);
    rd(4'h8, v); check("R1 restart reset", v, 32'h0);
    rd(4'hC, v); check("R1 status reset", v, 32'h0);
    check("R1 pulses low", {30'b0, irq, wdt_rst}, 32'h0);
    quiet(200, "R1 stopped after reset");

    // R2 R3 R4 random keyed and unkeyed writes
    for (int i = 0; i < 40; i++) begin
      logic [3:0] a;
      logic [31:0] d;
      logic [3:0] be;
      a = ($urandom % 2) ? 4'h4 : 4'h0;
      if ($urandom % 6 == 0) a = a | 4'($urandom % 3 + 1);
      d = $urandom;
      if ($urandom % 2) begin
        if (a[2]) d[25:14] = 12'h248;
        else      d[23:12] = 12'hABC;
      end
      be = ($urandom % 4 == 0) ? 4'($urandom) : 4'hF;
      wr(a, d, be);
      rd(4'h0, v); check("R2/R3 mode readback", v, exp_mode);
      rd(4'h4, v); check("R2/R4 control readback", v, exp_ctrl);
    end

    // R6 R7 basic expiry, shortest widths
    wr(4'h0, mode_word(0, 0, 0, 0, 0));
    wr(4'h4, ctrl_word(0, 0));
    wr(4'h0, mode_word(1, 1, 1, 0, 0));
    expect_expiry("basic", period(0, 0), 4, 2);

    // R8 hold after expiry
    quiet(400, "R8 no re-arm after expiry");
    rd(4'hC, v); check("R8 status sticky", v, 32'd1);

    // R5 status write ignored, restart reads zero, wrong key, R2 partial kick
    wr(4'hC, 32'h0);
    rd(4'hC, v); check("R5 status write ignored", v, 32'd1);
    wr(4'h8, 32'h0000_1999, 4'h3);
    rd(4'hC, v); check("R2 partial kick ignored", v, 32'd1);
    wr(4'h8, 32'h0000_1998);
    rd(4'hC, v); check("R5 wrong kick key ignored", v, 32'd1);
    rd(4'h8, v); check("R5 restart reads zero", v, 32'd0);

    // R4 control write does not reload; R7 widest widths
    wr(4'h4, ctrl_word(2, 1));
    rd(4'hC, v); check("R4 control write no reload", v, 32'd1);
    wr(4'h0, mode_word(1, 1, 1, 7, 3));
    rd(4'hC, v); check("R9 mode write clears status", v, 32'd0);
    expect_expiry("wide", period(2, 1), 32, 256);

    // R5 kick mid-count restarts the full period
    wr(4'h4, ctrl_word(1, 0));
    wr(4'h0, mode_word(1, 0, 1, 0, 1));
    quiet(200, "R5 no expiry before kick");
    wr(4'h8, 32'hABCD_1999);
    expect_expiry("kick", period(1, 0), 8, 0);

    // R9 disabled kick does nothing; disable mid-count keeps status
    wr(4'h0, mode_word(0, 1, 1, 0, 0));
    wr(4'h8, 32'h0000_1999);
    quiet(300, "R9 kick while disabled");
    rd(4'hC, v); check("R9 status kept when disabled", v, 32'd1);
    wr(4'h0, mode_word(1, 1, 1, 0, 0));
    rd(4'hC, v); check("R9 enable clears status", v, 32'd0);
    quiet(50, "R9 running before stop");
    wr(4'h0, mode_word(0, 1, 1, 0, 0));
    quiet(400, "R9 stop halts count");
    rd(4'hC, v); check("R9 stop leaves status", v, 32'd0);
    wr(4'hC, 32'hFFFF_FFFF);
    rd(4'hC, v); check("R5 status write of ones ignored", v, 32'd0);

    // R6 slowest divider
    wr(4'h4, ctrl_word(0, 3));
    wr(4'h0, mode_word(1, 1, 1, 1, 2));
    expect_expiry("slow", period(0, 3), 16, 4);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule